// File: doc/BRIEF.md
# DDS Load Sequencer

This block is the host-side controller for an external direct digital synthesis device. A requester places a 32-bit tuning word, a 5-bit phase offset and a power-down flag on the inputs, selects either byte-wide or single-bit transfer, and pulses `start`. The sequencer then drives the device's word strobe, update strobe and 8-bit data lines. Every strobe edge is spaced by a programmable number of system clock cycles, so a single build can meet the device's nanosecond limits at any system clock rate.

In single-bit transfer the device has to be switched into that mode once after reset. The sequencer does this by itself before the first single-bit load. It sends one byte-wide word with the low control pattern 011, then an update pulse, and then the 40-bit frame. All later single-bit loads skip this step until the next reset. The two device control bits are always sent as zero, so reserved test codes can never reach the device.

Top module: `dds_prog_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `wclk`, `fqud`, `busy` and `done` are 0 and `dbus` is 8'h00.
- R2: With `par_mode`=1, five `wclk` pulses carry bytes in this order: byte 0 = {phase[4:0], pdn, 2'b00} (phase in bits 7:3, power-down in bit 2), then ftw[31:24], ftw[23:16], ftw[15:8], ftw[7:0]. Exactly one `fqud` pulse follows.
- R3: With `par_mode`=0, forty `wclk` pulses carry one bit each on `dbus[7]`, while `dbus[6:0]` stays 0. The bit order is ftw[0] up to ftw[31], then two control bits, then pdn, then phase[0] up to phase[4]. Exactly one `fqud` pulse follows.
- R4: The two control bits are always 0: bits 1:0 of byte 0 in byte-wide transfer, and frame bits 32 and 33 in single-bit transfer.
- R5: The first single-bit load after reset is preceded by one `wclk` pulse with `dbus`=8'h03 (control pattern 011 on bits 2:0) and one `fqud` pulse. Later single-bit loads before the next reset omit this step.
- R6: `dbus` is stable for at least SETUP_CYC cycles before each `wclk` rise and does not change while `wclk` is high. `wclk` is high for at least WHIGH_CYC cycles and low for at least WLOW_CYC cycles between pulses.
- R7: `fqud` rises at least FDLY_CYC cycles after the last `wclk` fall and stays high for at least FHIGH_CYC cycles. The next `wclk` rise comes at least FLOW_CYC cycles after `fqud` falls.
- R8: `busy` is 1 from the cycle after an accepted `start` until the guard interval after the final `fqud` pulse ends. A `start` seen while `busy` is 1 is ignored.
- R9: `done` is a single-cycle pulse, issued in the cycle in which `busy` returns to 0.
- R10: `wclk` and `fqud` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a load; sampled while idle |
| par_mode | input | 1 | 1 = byte-wide transfer, 0 = single-bit transfer |
| ftw_in | input | 32 | Requested tuning word |
| phase_in | input | 5 | Requested phase offset |
| pdn_in | input | 1 | Requested power-down flag |
| busy | output | 1 | A load sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| wclk | output | 1 | Word load strobe to the device |
| fqud | output | 1 | Update strobe to the device |
| dbus | output | 8 | Data lines to the device; bit 7 carries single-bit data |

## Verification
Some properties are checked by assertions on every cycle. These are: strobe exclusivity, data held stable while the word strobe is high, zero control bits at their frame positions, the mode-entry step occurring only before the mode is active, requests ignored while busy, and the single-cycle `done` pulse. Bit and byte order, the mode-entry step happening exactly once per reset, and the minimum spacing between strobe edges can only be shown by the bench's scenarios. There, a behavioural receiver rebuilds the word from the pins and measures each interval in cycles.

// File: rtl/dds_seq_pkg.sv
`timescale 1ns/1ps
package dds_seq_pkg;

  localparam int FTW_W      = 32;
  localparam int PH_W       = 5;
  localparam int BUS_W      = 8;
  localparam int FRAME_BITS = FTW_W + 2 + 1 + PH_W;
  localparam int BYTE_COUNT = FRAME_BITS / BUS_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WHIGH,
    ST_WLOW,
    ST_FDLY,
    ST_FHIGH,
    ST_FLOW
  } seq_state_e;

  typedef struct packed {
    logic [PH_W-1:0]  phase;
    logic             pdn;
    logic [FTW_W-1:0] ftw;
  } dds_req_t;

endpackage

// File: rtl/dds_frame_builder.sv
`timescale 1ns/1ps
module dds_frame_builder
  import dds_seq_pkg::*;
(
  input  dds_req_t         req,
  input  logic [IDX_W-1:0] item_idx,
  input  logic             par_mode,
  input  logic             entry_phase,
  output logic [BUS_W-1:0] bus_val
);

  localparam logic [BUS_W-1:0] ENTRY_WORD = BUS_W'(3'b011);
  localparam int               BSEL_W     = $clog2(BYTE_COUNT);

  logic [FRAME_BITS-1:0] frame;
  logic [BUS_W-1:0]      par_bytes [BYTE_COUNT];
  logic                  ser_bit;

  // control bits are forced to zero in both layouts
  assign frame        = {req.phase, req.pdn, 2'b00, req.ftw};
  assign par_bytes[0] = {req.phase, req.pdn, 2'b00};

  generate
    for (genvar k = 1; k < BYTE_COUNT; k++) begin : g_ftw_byte
      assign par_bytes[k] = req.ftw[FTW_W-BUS_W*k +: BUS_W];
    end
  endgenerate

  assign ser_bit = frame[item_idx];

  always_comb begin
    if (entry_phase) begin
      bus_val = ENTRY_WORD;
    end else if (par_mode) begin
      if (item_idx < IDX_W'(BYTE_COUNT)) bus_val = par_bytes[item_idx[BSEL_W-1:0]];
      else                               bus_val = '0;
    end else begin
      bus_val = {ser_bit, {(BUS_W-1){1'b0}}};
    end
  end

endmodule

// File: rtl/dds_interval_timer.sv
`timescale 1ns/1ps
module dds_interval_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  assert_timer_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/dds_prog_seq.sv
`timescale 1ns/1ps
module dds_prog_seq
  import dds_seq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WHIGH_CYC = 1,
  parameter int WLOW_CYC  = 1,
  parameter int FDLY_CYC  = 2,
  parameter int FHIGH_CYC = 2,
  parameter int FLOW_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             par_mode,
  input  logic [31:0]      ftw_in,
  input  logic [4:0]       phase_in,
  input  logic             pdn_in,
  output logic             busy,
  output logic             done,
  output logic             wclk,
  output logic             fqud,
  output logic [7:0]       dbus
);

  localparam int MAX_A = (SETUP_CYC > WHIGH_CYC) ? SETUP_CYC : WHIGH_CYC;
  localparam int MAX_B = (WLOW_CYC  > FDLY_CYC)  ? WLOW_CYC  : FDLY_CYC;
  localparam int MAX_C = (FHIGH_CYC > FLOW_CYC)  ? FHIGH_CYC : FLOW_CYC;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CW = $clog2(MAX_CYC + 1) + 1;
  localparam logic [IDX_W-1:0] LAST_SER = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_PAR = IDX_W'(BYTE_COUNT - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             entry_q, entry_d;
  logic             ser_on_q, ser_on_d;
  logic             mode_q, mode_d;
  dds_req_t         req_q, req_d;
  logic             req_en;

  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_exp;
  logic [IDX_W-1:0] last_idx;
  logic [BUS_W-1:0] bus_next;
  logic             data_en;
  logic             done_d;

  dds_interval_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  dds_frame_builder u_builder (
    .req         (req_d),
    .item_idx    (idx_d),
    .par_mode    (mode_d),
    .entry_phase (entry_d),
    .bus_val     (bus_next)
  );

  always_comb begin
    if (entry_q)     last_idx = '0;
    else if (mode_q) last_idx = LAST_PAR;
    else             last_idx = LAST_SER;
  end

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    entry_d  = entry_q;
    ser_on_d = ser_on_q;
    mode_d   = mode_q;
    req_d    = req_q;
    req_en   = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          req_en  = 1'b1;
          req_d   = '{phase: phase_in, pdn: pdn_in, ftw: ftw_in};
          mode_d  = par_mode;
          entry_d = !par_mode && !ser_on_q;
          idx_d   = '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: if (tmr_exp) state_d = ST_WHIGH;
      ST_WHIGH: if (tmr_exp) state_d = ST_WLOW;
      ST_WLOW: begin
        if (tmr_exp) begin
          if (idx_q == last_idx) begin
            state_d = ST_FDLY;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_SETUP;
          end
        end
      end
      ST_FDLY:  if (tmr_exp) state_d = ST_FHIGH;
      ST_FHIGH: if (tmr_exp) state_d = ST_FLOW;
      ST_FLOW: begin
        if (tmr_exp) begin
          if (entry_q) begin
            entry_d  = 1'b0;
            ser_on_d = 1'b1;
            idx_d    = '0;
            state_d  = ST_SETUP;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // timer reload on every state change with the new state's interval
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_SETUP: tmr_val = CW'(SETUP_CYC - 1);
      ST_WHIGH: tmr_val = CW'(WHIGH_CYC - 1);
      ST_WLOW:  tmr_val = CW'(WLOW_CYC  - 1);
      ST_FDLY:  tmr_val = CW'(FDLY_CYC  - 1);
      ST_FHIGH: tmr_val = CW'(FHIGH_CYC - 1);
      ST_FLOW:  tmr_val = CW'(FLOW_CYC  - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign data_en = (state_d == ST_SETUP) && (state_q != ST_SETUP);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      entry_q  <= 1'b0;
      ser_on_q <= 1'b0;
      mode_q   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      wclk     <= 1'b0;
      fqud     <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      entry_q  <= entry_d;
      ser_on_q <= ser_on_d;
      mode_q   <= mode_d;
      busy     <= (state_d != ST_IDLE);
      done     <= done_d;
      wclk     <= (state_d == ST_WHIGH);
      fqud     <= (state_d == ST_FHIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbus <= '0;
    else if (data_en) dbus <= bus_next;
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wclk && fqud));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wclk |-> $stable(dbus));

  assert_ctrl_ser_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk && !mode_q && !entry_q && (idx_q == IDX_W'(32) || idx_q == IDX_W'(33)))
      |-> (dbus[7] == 1'b0));

  assert_ctrl_par_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk && mode_q && idx_q == '0) |-> (dbus[1:0] == 2'b00));

  assert_entry_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> !ser_on_q);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(req_q));

  assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk || fqud) |-> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_dds_prog_seq.sv
`timescale 1ns/1ps
module tb_dds_prog_seq;

  localparam int SU = 2;
  localparam int WH = 3;
  localparam int WL = 2;
  localparam int FD = 2;
  localparam int FH = 3;
  localparam int FL = 2;
  localparam int NVEC = 6;

  // {par_mode, pdn, phase[4:0], ftw[31:0]}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'h00, 32'h1234_5678},
    {1'b1, 1'b1, 5'h1F, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 5'h15, 32'h0000_0001},
    {1'b0, 1'b0, 5'h0A, 32'h8000_0001},
    {1'b0, 1'b1, 5'h11, 32'hA5A5_5A5A},
    {1'b0, 1'b0, 5'h1F, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, par_mode, pdn_in;
  logic [31:0] ftw_in;
  logic [4:0]  phase_in;
  logic        busy, done, wclk, fqud;
  logic [7:0]  dbus;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dds_prog_seq #(
    .SETUP_CYC(SU), .WHIGH_CYC(WH), .WLOW_CYC(WL),
    .FDLY_CYC(FD), .FHIGH_CYC(FH), .FLOW_CYC(FL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .par_mode(par_mode),
    .ftw_in(ftw_in), .phase_in(phase_in), .pdn_in(pdn_in),
    .busy(busy), .done(done), .wclk(wclk), .fqud(fqud), .dbus(dbus)
  );

  // behavioural receiver model of the programmed device
  int          cyc, t_dchg, t_wr, t_wf, t_fr, t_ff;
  logic        pw, pf;
  logic [7:0]  pbus;
  logic        smode;
  int          ptr, scnt;
  logic [7:0]  pb [5];
  logic [39:0] sreg;
  int          nviol, nerr, nload, nen;
  logic [31:0] rf;
  logic [4:0]  rph;
  logic        rpd;
  logic [1:0]  rctl;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; t_dchg = -1000; t_wr = -1000; t_wf = -1000; t_fr = -1000; t_ff = -1000;
      pw = 0; pf = 0; pbus = 8'h00; smode = 0; ptr = 0; scnt = 0; sreg = '0;
      nviol = 0; nerr = 0; nload = 0; nen = 0;
      rf = '0; rph = '0; rpd = 0; rctl = '0;
    end else begin
      cyc++;
      if (dbus !== pbus) begin
        if (pw || wclk) begin nviol++; $display("timing: data moved while wclk high at %0d", cyc); end
        t_dchg = cyc;
      end
      if (wclk && fqud) nviol++;
      if (wclk && !pw) begin
        if (cyc - t_dchg < SU) nviol++;
        if (cyc - t_wf < WL) nviol++;
        if (cyc - t_ff < FL) nviol++;
        if (smode) begin
          sreg = {dbus[7], sreg[39:1]};
          scnt++;
          if (dbus[6:0] != 7'd0) nerr++;
        end else begin
          if (ptr < 5) pb[ptr] = dbus;
          ptr++;
        end
        t_wr = cyc;
      end
      if (!wclk && pw) begin
        if (cyc - t_wr < WH) nviol++;
        t_wf = cyc;
      end
      if (fqud && !pf) begin
        if (cyc - t_wf < FD) nviol++;
        if (smode) begin
          if (scnt != 40) nerr++;
          rf = sreg[31:0]; rctl = sreg[33:32]; rpd = sreg[34]; rph = sreg[39:35];
          nload++; scnt = 0;
        end else if (ptr == 1 && pb[0][2:0] == 3'b011) begin
          smode = 1; nen++;
        end else begin
          if (ptr != 5) nerr++;
          rph = pb[0][7:3]; rpd = pb[0][2]; rctl = pb[0][1:0];
          rf = {pb[1], pb[2], pb[3], pb[4]};
          nload++;
        end
        ptr = 0;
        t_fr = cyc;
      end
      if (!fqud && pf) begin
        if (cyc - t_fr < FH) nviol++;
        t_ff = cyc;
      end
      pw = wclk; pf = fqud; pbus = dbus;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(wclk == 0 && fqud == 0, "R1", "strobes in reset", {wclk, fqud}, 0);
    check(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dbus == 8'h00 && !busy, "R1", "after release", {busy, dbus}, 0);
  endtask

  task automatic launch(input logic [38:0] v);
    par_mode = v[38]; pdn_in = v[37]; phase_in = v[36:32]; ftw_in = v[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    bit seen_ser;
    int loads0, en_exp;
    logic [31:0] a_ftw;
    par_mode = 1'b1; pdn_in = 1'b0; phase_in = '0; ftw_in = '0;
    seen_ser = 0;
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      loads0 = nload;
      launch(VEC[i]);
      wait_done();
      if (!VEC[i][38]) seen_ser = 1;
      en_exp = seen_ser ? 1 : 0;
      check(rf == VEC[i][31:0], VEC[i][38] ? "R2" : "R3", "tuning word", rf, VEC[i][31:0]);
      check(rph == VEC[i][36:32], VEC[i][38] ? "R2" : "R3", "phase", rph, VEC[i][36:32]);
      check(rpd == VEC[i][37], VEC[i][38] ? "R2" : "R3", "power-down", rpd, VEC[i][37]);
      check(rctl == 2'b00, "R4", "control bits", rctl, 0);
      check(nload == loads0 + 1, "R2", "one update per load", nload, loads0 + 1);
      check(nen == en_exp, "R5", "mode entry count", nen, en_exp);
      check(nerr == 0, "R3", "frame length/idle lines", nerr, 0);
      check(nviol == 0, "R6", "strobe timing R7", nviol, 0);
    end

    // start while busy is ignored
    do_reset();
    a_ftw = 32'hCAFE_0042;
    loads0 = nload;
    launch({1'b1, 1'b0, 5'h03, a_ftw});
    repeat (6) @(negedge clk);
    ftw_in = 32'h0BAD_0BAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(rf == a_ftw, "R8", "word while busy", rf, a_ftw);
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R8", "no second sequence", busy, 0);
    check(nload == loads0 + 1, "R8", "single update", nload, loads0 + 1);

    // reset mid-sequence, then serial entry must repeat
    launch({1'b0, 1'b1, 5'h05, 32'h1357_9BDF});
    repeat (40) @(negedge clk);
    do_reset();
    check(nen == 0, "R5", "entry cleared by reset", nen, 0);
    launch({1'b0, 1'b1, 5'h05, 32'h1357_9BDF});
    wait_done();
    check(nen == 1, "R5", "entry after reset", nen, 1);
    check(rf == 32'h1357_9BDF && rph == 5'h05 && rpd, "R3", "serial after reset", rf, 32'h1357_9BDF);
    check(nviol == 0, "R10", "no overlap / timing", nviol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule